// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits next to a job-completion ring and decides when the host should be interrupted. Each completed job arrives as a one-cycle pulse, and each entry that software takes off the ring arrives as a separate one-cycle retire pulse. The block keeps a count of the completions that are still pending. It raises one level-sensitive interrupt when either of two conditions is met first. The first is that the pending count reaches a programmable count limit. The second is that a programmable timeout expires. The timeout is measured in ticks of 64 bus clocks, and the tick timer runs only while something is pending.

Software supplies the count limit (8 bits), the tick limit (16 bits) and a coalescing enable on plain input ports. With coalescing off, every completion raises the interrupt directly. The interrupt stays high until software pulses the acknowledge input. The ring depth is a power of two fixed by the parameter `RING_EXP`, which is the exponent and ranges from 2 to 9.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset the interrupt output is 0 and nothing is pending. While nothing is pending and no completion arrives, the interrupt stays 0.
- R2: With coalescing on and an effective count limit N below the ring depth, the interrupt rises one cycle after the clock edge on which the pending count becomes N or more.
- R3: With coalescing on, the interrupt rises 64*T clocks after the edge that captured the first completion, where T is the effective tick limit, provided the count limit has not been reached before then.
- R4: The prescaler and the tick counter are cleared whenever the pending count is zero and whenever the interrupt is raised. The next timeout is therefore measured again from the next completion or from the raise.
- R5: If the count limit is equal to or greater than the ring depth, the count condition never fires, and the interrupt comes only from the timeout.
- R6: With coalescing off (`coal_en`=0), the interrupt rises one cycle after each completion, whatever the limits are.
- R7: The interrupt is a level that holds until `irq_ack` is pulsed, and it reads 0 in the cycle after the acknowledge. If the count condition still holds, it returns to 1 one cycle later.
- R8: A count limit of 0 behaves as 1, and a tick limit of 0 behaves as 1.
- R9: The pending count stops at the ring depth (8 entries in the bench). Retire pulses lower it, and it never goes below zero.
- R10: A completion and a retire in the same cycle leave the pending count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coal_en | input | 1 | 1 = coalescing on, 0 = interrupt on every completion |
| cnt_limit | input | 8 | Completion count limit (0 treated as 1) |
| tick_limit | input | 16 | Timeout in 64-clock ticks (0 treated as 1) |
| job_done | input | 1 | One-cycle pulse per completed job |
| sw_retire | input | 1 | One-cycle pulse per entry retired by software |
| irq_ack | input | 1 | One-cycle acknowledge that clears the interrupt |
| irq | output | 1 | Level interrupt to the host |

## Verification
The case that is hardest to reach from the ports is showing that the timer is really cleared, and not just frozen, when the pending count drops to zero or when a timeout raise occurs. A frozen timer and a cleared timer both stay quiet for a while. The stimulus first lets the timer run part-way, then retires the only pending entry, then queues a new completion, and checks that the interrupt comes exactly 64*T clocks after the new completion. It then acknowledges the raise and checks that the next timeout is a full 64*T clocks later. A tick limit of 2 makes a stale tick count show up as an early interrupt.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Threshold floor: a zero limit behaves as one
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Pending-count update: saturating add, floored subtract, hold on collision
  function automatic int unsigned pend_step(input int unsigned cur, input logic inc,
                                            input logic dec, input int unsigned cap);
    if (inc && !dec) return (cur >= cap) ? cap : cur + 1;
    if (dec && !inc) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction
endpackage

// File: rtl/cic_pend_counter.sv
module cic_pend_counter #(
  parameter int RING_EXP = 9,
  localparam int DEPTH = 1 << RING_EXP,
  localparam int PW = RING_EXP + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] level
);
  import cic_pkg::*;

  logic [PW-1:0] level_q;
  logic [PW-1:0] level_n;

  always_comb level_n = PW'(pend_step(32'(level_q), inc, dec, DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_n;
  end

  assign level = level_q;
endmodule

// File: rtl/cic_tick_timer.sv
module cic_tick_timer #(
  parameter int PRE_W = 6,
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [TW-1:0]    limit,
  output logic             expire,
  output logic [PRE_W-1:0] pre,
  output logic [TW-1:0]    ticks
);
  logic [PRE_W-1:0] pre_q;
  logic [TW-1:0]    ticks_q;
  logic             tick_edge;

  assign tick_edge = run && (&pre_q);
  assign expire    = tick_edge && (ticks_q >= limit - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (tick_edge && !(&ticks_q)) ticks_q <= ticks_q + TW'(1);
    end
  end

  assign pre   = pre_q;
  assign ticks = ticks_q;
endmodule

// File: rtl/cic_irq_latch.sv
module cic_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (ack)   irq_q <= 1'b0;
    else if (raise) irq_q <= 1'b1;
  end

  assign irq = irq_q;
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer #(
  parameter int RING_EXP = 9,
  parameter int CNT_W = 8,
  parameter int TIME_W = 16,
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coal_en,
  input  logic [CNT_W-1:0]  cnt_limit,
  input  logic [TIME_W-1:0] tick_limit,
  input  logic              job_done,
  input  logic              sw_retire,
  input  logic              irq_ack,
  output logic              irq
);
  import cic_pkg::*;

  localparam int DEPTH = 1 << RING_EXP;
  localparam int PW = RING_EXP + 1;
  localparam int CMP_W = ((CNT_W > PW) ? CNT_W : PW) + 1;

  logic [PW-1:0]            pend_level;
  logic [CNT_W-1:0]         cnt_eff;
  logic [TIME_W-1:0]        tick_eff;
  logic [CMP_W-1:0]         pend_x;
  logic [CMP_W-1:0]         thr_x;
  logic                     count_hit;
  logic                     time_hit;
  logic                     timer_run;
  logic                     raise;
  logic [PRESCALE_LOG2-1:0] pre_cnt;
  logic [TIME_W-1:0]        tick_cnt;

  assign cnt_eff  = CNT_W'(at_least_one(32'(cnt_limit)));
  assign tick_eff = TIME_W'(at_least_one(32'(tick_limit)));

  cic_pend_counter #(.RING_EXP(RING_EXP)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(job_done), .dec(sw_retire), .level(pend_level)
  );

  assign pend_x    = CMP_W'(pend_level);
  assign thr_x     = CMP_W'(cnt_eff);
  assign count_hit = coal_en && (thr_x < CMP_W'(DEPTH)) && (pend_x >= thr_x);
  assign timer_run = coal_en && (pend_level != '0);

  cic_tick_timer #(.PRE_W(PRESCALE_LOG2), .TW(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .clear(raise), .limit(tick_eff),
    .expire(time_hit), .pre(pre_cnt), .ticks(tick_cnt)
  );

  assign raise = !irq_ack && (coal_en ? (count_hit || time_hit) : job_done);

  cic_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .raise(raise), .ack(irq_ack), .irq(irq)
  );
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int RING_EXP = 9,
  parameter int PRE_W = 6,
  parameter int TW = 16,
  localparam int PW = RING_EXP + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coal_en,
  input logic          job_done,
  input logic          sw_retire,
  input logic          irq_ack,
  input logic          irq,
  input logic [PW-1:0] pend,
  input logic          count_hit,
  input logic [PRE_W-1:0] pre,
  input logic [TW-1:0] ticks
);
  localparam logic [PW-1:0] CAP = PW'(1 << RING_EXP);

  a_r9_pend_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CAP);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && sw_retire && !job_done) |=> pend == '0);
  a_r10_collision_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (job_done && sw_retire) |=> pend == $past(pend));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);
  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  a_r6_direct_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!coal_en && job_done && !irq_ack) |=> irq);
  a_r2_count_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hit && !irq_ack) |=> irq);
  a_r4_idle_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (pre == '0 && ticks == '0));
endmodule

bind cmpl_irq_coalescer cic_checker #(
  .RING_EXP(RING_EXP), .PRE_W(PRESCALE_LOG2), .TW(TIME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .coal_en(coal_en), .job_done(job_done),
  .sw_retire(sw_retire), .irq_ack(irq_ack), .irq(irq), .pend(pend_level),
  .count_hit(count_hit), .pre(pre_cnt), .ticks(tick_cnt)
);

// File: tb/cmpl_irq_coalescer_bench.sv
`timescale 1ns/1ps
module cmpl_irq_coalescer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coal_en = 1'b1;
  logic [7:0]  cnt_limit = 8'd1;
  logic [15:0] tick_limit = 16'd1;
  logic        job_done = 1'b0;
  logic        sw_retire = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmpl_irq_coalescer #(.RING_EXP(3)) u_cmpl_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .coal_en(coal_en), .cnt_limit(cnt_limit),
    .tick_limit(tick_limit), .job_done(job_done), .sw_retire(sw_retire),
    .irq_ack(irq_ack), .irq(irq)
  );

  task automatic check_irq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq=%b expected %b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic en, input logic [7:0] cl, input logic [15:0] tl);
    @(negedge clk);
    rst_n = 1'b0; job_done = 1'b0; sw_retire = 1'b0; irq_ack = 1'b0;
    coal_en = en; cnt_limit = cl; tick_limit = tl;
    step(2);
    rst_n = 1'b1;
  endtask

  // Each pulse task starts at a negedge and is captured on the next edge
  task automatic pulse_done();
    job_done = 1'b1; @(negedge clk); job_done = 1'b0;
  endtask
  task automatic pulse_retire();
    sw_retire = 1'b1; @(negedge clk); sw_retire = 1'b0;
  endtask
  task automatic pulse_ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask
  task automatic pulse_both();
    job_done = 1'b1; sw_retire = 1'b1; @(negedge clk);
    job_done = 1'b0; sw_retire = 1'b0;
  endtask

  task automatic t_reset_idle();
    do_reset(1'b1, 8'd1, 16'd1);
    check_irq("R1 after reset", 1'b0);
    step(300);
    check_irq("R1 idle no pending", 1'b0);
  endtask

  task automatic t_count();
    do_reset(1'b1, 8'd3, 16'd1000);
    pulse_done(); pulse_done(); pulse_done();
    check_irq("R2 count just reached", 1'b0);
    step(1);
    check_irq("R2 count raise", 1'b1);
    pulse_ack();
    check_irq("R7 ack clears", 1'b0);
    step(1);
    check_irq("R7 reassert while count met", 1'b1);
    pulse_retire();
    pulse_ack();
    step(2);
    check_irq("R7 stays low below limit", 1'b0);
    // spaced completions
    do_reset(1'b1, 8'd4, 16'd1000);
    pulse_done(); step(4); pulse_done(); step(3); pulse_done(); step(10);
    check_irq("R2 three of four spaced", 1'b0);
    pulse_done();
    check_irq("R2 four captured", 1'b0);
    step(1);
    check_irq("R2 spaced raise", 1'b1);
  endtask

  task automatic t_timeout();
    do_reset(1'b1, 8'd200, 16'd3);
    pulse_done();
    step(191);
    check_irq("R3 before 3 ticks", 1'b0);
    step(1);
    check_irq("R3 timeout at 192", 1'b1);
  endtask

  task automatic t_timer_clear();
    do_reset(1'b1, 8'd200, 16'd2);
    pulse_done();
    step(39);
    pulse_retire();
    step(9);
    pulse_done();
    step(127);
    check_irq("R4 cleared at zero pending", 1'b0);
    step(1);
    check_irq("R4 timeout from new completion", 1'b1);
    pulse_ack();
    check_irq("R7 ack after timeout", 1'b0);
    step(126);
    check_irq("R4 cleared on raise", 1'b0);
    step(1);
    check_irq("R4 second timeout", 1'b1);
  endtask

  task automatic t_unreachable();
    do_reset(1'b1, 8'd8, 16'd2);
    for (int i = 0; i < 8; i++) pulse_done();
    step(120);
    check_irq("R5 no count raise at depth", 1'b0);
    step(1);
    check_irq("R5 timeout only", 1'b1);
  endtask

  task automatic t_direct();
    do_reset(1'b0, 8'd200, 16'd1);
    pulse_done();
    check_irq("R6 direct raise", 1'b1);
    pulse_ack();
    step(100);
    check_irq("R6 no timer when off", 1'b0);
    pulse_done();
    check_irq("R6 second direct raise", 1'b1);
  endtask

  task automatic t_zero_limits();
    do_reset(1'b1, 8'd0, 16'd1000);
    pulse_done();
    check_irq("R8 zero count limit pending", 1'b0);
    step(1);
    check_irq("R8 zero count limit as one", 1'b1);
    do_reset(1'b1, 8'd200, 16'd0);
    pulse_done();
    step(63);
    check_irq("R8 zero tick limit as one", 1'b0);
    step(1);
    check_irq("R8 zero tick limit raise", 1'b1);
  endtask

  task automatic t_saturate();
    do_reset(1'b1, 8'd7, 16'd1000);
    for (int i = 0; i < 10; i++) pulse_done();
    check_irq("R9 raise at seven", 1'b1);
    pulse_retire(); pulse_retire();
    pulse_ack();
    step(2);
    check_irq("R9 saturated at depth", 1'b0);
    do_reset(1'b1, 8'd2, 16'd1000);
    pulse_retire(); pulse_retire(); pulse_retire();
    pulse_done();
    step(3);
    check_irq("R9 floor at zero", 1'b0);
  endtask

  task automatic t_collision();
    do_reset(1'b1, 8'd2, 16'd1000);
    pulse_done();
    pulse_both();
    step(2);
    check_irq("R10 collision holds count", 1'b0);
    pulse_done();
    step(1);
    check_irq("R10 next completion reaches limit", 1'b1);
  endtask

  initial begin
    t_reset_idle();
    t_count();
    t_timeout();
    t_timer_clear();
    t_unreachable();
    t_direct();
    t_zero_limits();
    t_saturate();
    t_collision();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule